// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-Down Controller

This block decides when a two-bank SDRAM may drop its clock enable to save standby power, and when it must raise it again. A scheduler sends a sleep request. A bank tracker reports whether a read or write burst is still running and which banks hold an open row. The controller lowers CKE only while no access is running. It records whether the sleep began with every bank idle (precharge power-down) or with a row held open (active power-down). While asleep it drives only the no-operation command.

No refresh can run while CKE is low, so the controller counts the cycles it has spent asleep. It wakes the device on its own before the refresh interval runs out, leaving a margin so that the refresh engine can schedule a refresh straight after the wake-up. An external wake request also ends the sleep.

CKE and the command bus are both registered. CKE returns high at the exit edge, and a run of NOP cycles follows before any queued command is accepted. The sampling edge after the wake-up therefore sees CKE high with a full cycle of setup.

Top module: `sdpd_ctrl`

## Requirements
- R1: During and just after reset, cke_o is 1, cmd_o is NOP (4'b0111 as {cs_n,ras_n,cas_n,we_n}), pd_mode_o is 2'b00 and timeout_o is 0.
- R2: When pd_req is sampled high with busy_i low in normal operation, cke_o is 0 and cmd_o is NOP in the cycle that follows.
- R3: While busy_i is high, pd_req has no effect: cke_o stays 1 and the requested commands still pass to cmd_o.
- R4: The mode code is captured at the entry edge. It is 2'b01 (precharge power-down) if every row_open_i bit is 0, and 2'b10 (active power-down) if any bit is 1. The code holds for the whole low-CKE period, even if row_open_i changes, and reads 2'b00 whenever cke_o is 1.
- R5: While cke_o is 0, cmd_o is NOP, cmd_req_ready is 0, and no requested command is forwarded.
- R6: When wake_req is sampled high during power-down, the next cycle shows cke_o at 1, cmd_o at NOP and pd_mode_o at 2'b00.
- R7: cke_o stays low for at most RES_LIMIT = CLK_KHZ*REFRESH_MS - MARGIN_CYC consecutive cycles. Without a wake request, the controller exits after exactly RES_LIMIT cycles, and timeout_o is 1 for the single first cycle of high CKE.
- R8: After CKE rises, EXIT_NOPS cycles pass with cmd_o at NOP and cmd_req_ready at 0 before commands are accepted again.
- R9: In normal operation, a command with cmd_req_valid and cmd_req_ready both high appears on cmd_o one cycle later. With no request, cmd_o is NOP.
- R10: When pd_req is accepted, power-down entry wins over a pending command: cmd_req_ready is 0 in that cycle and the command is not issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and SDRAM clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pd_req | input | 1 | Request to enter power-down |
| wake_req | input | 1 | Request to leave power-down |
| busy_i | input | 1 | A read or write burst is in progress |
| row_open_i | input | NUM_BANKS | One bit per bank, set while the bank has an open row |
| cmd_req_valid | input | 1 | Upstream command is valid |
| cmd_req_code | input | 4 | Upstream command {cs_n,ras_n,cas_n,we_n} |
| cmd_req_ready | output | 1 | Upstream command is accepted this cycle |
| cke_o | output | 1 | Clock enable to the SDRAM |
| cmd_o | output | 4 | Registered command bus {cs_n,ras_n,cas_n,we_n} |
| pd_mode_o | output | 2 | 00 awake, 01 precharge power-down, 10 active power-down |
| timeout_o | output | 1 | One-cycle flag for an exit forced by the residency limit |

## Verification
A wrong sleep state shows up at the ports in the cycle after the edge that caused it. A controller that stays asleep holds cmd_req_ready low while CKE is already high, or keeps CKE low past the residency limit. A controller that wakes too early raises CKE before the limit with no wake request present. A corrupted mode register shows a mode code that disagrees with CKE, or that changes in the middle of a sleep. A broken exit count shows up as the first forwarded command landing one cycle early or late relative to the rise of CKE.

// File: rtl/sdpd_pkg.sv
// Shared types for the SDRAM power-down controller.
// Assumes commands are encoded as {cs_n, ras_n, cas_n, we_n}.
package sdpd_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_PD   = 2'b01,
        ST_EXIT = 2'b10
    } sdpd_state_e;

    localparam logic [1:0] MODE_NONE   = 2'b00;
    localparam logic [1:0] MODE_PRECHG = 2'b01;
    localparam logic [1:0] MODE_ACTIVE = 2'b10;

    localparam logic [3:0] CMD_NOP = 4'b0111;
endpackage

// File: rtl/sdpd_cycle_timer.sv
// Cycle counter with a terminal flag. It counts while run is high and
// returns to zero while clear is high. last is high in the cycle where the
// LIMIT-th counted cycle is in progress.
// Assumes LIMIT >= 1, and that the owner clears the counter after last.
module sdpd_cycle_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic last
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // count cycles spent in the watched state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/sdpd_mode_class.sv
// Classifies a power-down as precharge (all banks idle) or active (any row
// open) from the per-bank open-row flags.
// Assumes row_open is valid in the cycle in which entry is decided.
module sdpd_mode_class #(
    parameter int unsigned NUM_BANKS = 2
) (
    input  logic [NUM_BANKS-1:0] row_open,
    output logic [1:0]           mode_code
);
    import sdpd_pkg::*;

    logic [NUM_BANKS:0] any_chain;

    assign any_chain[0] = 1'b0;

    // OR chain across the banks
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign any_chain[g+1] = any_chain[g] | row_open[g];
    end

    // map "any row open" onto the mode code
    always_comb begin
        mode_code = any_chain[NUM_BANKS] ? MODE_ACTIVE : MODE_PRECHG;
    end
endmodule

// File: rtl/sdpd_fsm.sv
// Sequencer for the power-down controller: awake -> powered down -> exit
// NOP run -> awake. CKE is registered from the next state, so it moves at
// the same edge as the state and is high for the whole exit run, ahead of
// the first real command.
// Assumes the timers' last flags refer to the current state.
module sdpd_fsm (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pd_req,
    input  logic                  wake_req,
    input  logic                  busy,
    input  logic                  res_last,
    input  logic                  exit_last,
    input  logic [1:0]            mode_in,
    output sdpd_pkg::sdpd_state_e state,
    output logic                  enter,
    output logic                  cke_q,
    output logic [1:0]            mode_q,
    output logic                  timeout_q
);
    import sdpd_pkg::*;

    sdpd_state_e state_nx;
    logic        leave_pd;

    assign enter    = (state == ST_RUN) && pd_req && !busy;
    assign leave_pd = (state == ST_PD) && (wake_req || res_last);

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (enter)     state_nx = ST_PD;
            ST_PD:   if (leave_pd)  state_nx = ST_EXIT;
            ST_EXIT: if (exit_last) state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    // state, CKE, mode and timeout registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            cke_q     <= 1'b1;
            mode_q    <= MODE_NONE;
            timeout_q <= 1'b0;
        end else begin
            state     <= state_nx;
            cke_q     <= (state_nx != ST_PD);
            timeout_q <= leave_pd && res_last;
            if (enter) begin
                mode_q <= mode_in;
            end else if (leave_pd) begin
                mode_q <= MODE_NONE;
            end
        end
    end
endmodule

// File: rtl/sdpd_ctrl.sv
// SDRAM power-down controller top. Lowers CKE on request when no burst is
// running, records the power-down kind, holds NOP on the command bus while
// asleep, forces a wake-up before the refresh interval expires, and stalls
// upstream commands until the exit NOP run has finished.
// Assumes the bank tracker's busy and row-open flags are registered and
// refer to the current cycle.
module sdpd_ctrl #(
    parameter int unsigned NUM_BANKS  = 2,
    parameter int unsigned CLK_KHZ    = 100000,
    parameter int unsigned REFRESH_MS = 64,
    parameter int unsigned MARGIN_CYC = 1024,
    parameter int unsigned EXIT_NOPS  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pd_req,
    input  logic                 wake_req,
    input  logic                 busy_i,
    input  logic [NUM_BANKS-1:0] row_open_i,
    input  logic                 cmd_req_valid,
    input  logic [3:0]           cmd_req_code,
    output logic                 cmd_req_ready,
    output logic                 cke_o,
    output logic [3:0]           cmd_o,
    output logic [1:0]           pd_mode_o,
    output logic                 timeout_o
);
    import sdpd_pkg::*;

    localparam int unsigned RES_LIMIT = CLK_KHZ * REFRESH_MS - MARGIN_CYC;

    sdpd_state_e state;
    logic        enter;
    logic        res_last;
    logic        exit_last;
    logic [1:0]  mode_code;
    logic [3:0]  cmd_q;

    sdpd_mode_class #(.NUM_BANKS(NUM_BANKS)) u_class (
        .row_open  (row_open_i),
        .mode_code (mode_code)
    );

    sdpd_cycle_timer #(.LIMIT(RES_LIMIT)) u_res_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state != ST_PD),
        .run   (state == ST_PD),
        .last  (res_last)
    );

    sdpd_cycle_timer #(.LIMIT(EXIT_NOPS)) u_exit_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state != ST_EXIT),
        .run   (state == ST_EXIT),
        .last  (exit_last)
    );

    sdpd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_req    (pd_req),
        .wake_req  (wake_req),
        .busy      (busy_i),
        .res_last  (res_last),
        .exit_last (exit_last),
        .mode_in   (mode_code),
        .state     (state),
        .enter     (enter),
        .cke_q     (cke_o),
        .mode_q    (pd_mode_o),
        .timeout_q (timeout_o)
    );

    // accept commands only while awake and not entering power-down
    assign cmd_req_ready = (state == ST_RUN) && !enter;

    // command bus register: forward accepted commands, otherwise NOP
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_NOP;
        end else if (cmd_req_valid && cmd_req_ready) begin
            cmd_q <= cmd_req_code;
        end else begin
            cmd_q <= CMD_NOP;
        end
    end

    assign cmd_o = cmd_q;
endmodule

// File: rtl/sdpd_ctrl_chk.sv
// Port-level checker for sdpd_ctrl, attached with bind. It keeps its own
// count of consecutive low-CKE cycles to check the residency limit.
module sdpd_ctrl_chk #(
    parameter int unsigned LIMIT = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_i,
    input logic       cmd_req_ready,
    input logic       cke_o,
    input logic [3:0] cmd_o,
    input logic [1:0] pd_mode_o,
    input logic       timeout_o
);
    int unsigned low_cnt;

    // count consecutive cycles with CKE low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= 0;
        end else if (!cke_o) begin
            low_cnt <= low_cnt + 1;
        end else begin
            low_cnt <= 0;
        end
    end

    AST_ENTRY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_o) |-> $past(!busy_i)); // R3
    AST_SLEEP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o |-> (cmd_o == 4'b0111) && !cmd_req_ready); // R5
    AST_MODE_VS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_mode_o != 2'b00) == !cke_o); // R4
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_o && $past(!cke_o)) |-> $stable(pd_mode_o)); // R4
    AST_RESIDENCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o |-> (low_cnt < LIMIT)); // R7
    AST_TIMEOUT_AT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> cke_o && $past(!cke_o)); // R7
    AST_EXIT_NOP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> (cmd_o == 4'b0111) && !cmd_req_ready); // R8
    AST_ENTRY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_o) |-> (cmd_o == 4'b0111)); // R2
endmodule

bind sdpd_ctrl sdpd_ctrl_chk #(.LIMIT(RES_LIMIT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy_i        (busy_i),
    .cmd_req_ready (cmd_req_ready),
    .cke_o         (cke_o),
    .cmd_o         (cmd_o),
    .pd_mode_o     (pd_mode_o),
    .timeout_o     (timeout_o)
);

// File: tb/sdpd_ctrl_tb_top.sv
module sdpd_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 56;    // 1 * 64 - 8
    localparam logic [3:0] NOP  = 4'b0111;
    localparam logic [3:0] RD   = 4'b0101;
    localparam logic [3:0] ACTV = 4'b0011;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       pd_req = 0, wake_req = 0, busy_i = 0;
    logic [1:0] row_open_i = '0;
    logic       cmd_req_valid = 0;
    logic [3:0] cmd_req_code = NOP;
    logic       cmd_req_ready, cke_o, timeout_o;
    logic [3:0] cmd_o;
    logic [1:0] pd_mode_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdpd_ctrl #(
        .NUM_BANKS(2), .CLK_KHZ(1), .REFRESH_MS(64),
        .MARGIN_CYC(8), .EXIT_NOPS(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .wake_req(wake_req),
        .busy_i(busy_i), .row_open_i(row_open_i),
        .cmd_req_valid(cmd_req_valid), .cmd_req_code(cmd_req_code),
        .cmd_req_ready(cmd_req_ready), .cke_o(cke_o), .cmd_o(cmd_o),
        .pd_mode_o(pd_mode_o), .timeout_o(timeout_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        step();
        step();
        chk(cke_o == 1, "R1 cke", cke_o, 1);
        chk(cmd_o == NOP, "R1 cmd", cmd_o, NOP);
        chk(pd_mode_o == 2'b00, "R1 mode", pd_mode_o, 0);
        rst_n = 1;
        step();
        chk(timeout_o == 0, "R1 timeout", timeout_o, 0);
        chk(cke_o == 1, "R1 cke after release", cke_o, 1);
    endtask

    task automatic t_passthru();
        cmd_req_valid = 1; cmd_req_code = RD;
        #1 chk(cmd_req_ready == 1, "R9 ready", cmd_req_ready, 1);
        step();
        chk(cmd_o == RD, "R9 forward", cmd_o, RD);
        cmd_req_valid = 0;
        step();
        chk(cmd_o == NOP, "R9 idle nop", cmd_o, NOP);
    endtask

    task automatic t_busy_block();
        pd_req = 1; busy_i = 1; cmd_req_valid = 1; cmd_req_code = RD;
        #1 chk(cmd_req_ready == 1, "R3 ready while busy", cmd_req_ready, 1);
        step();
        chk(cke_o == 1, "R3 cke held", cke_o, 1);
        chk(cmd_o == RD, "R3 cmd passes", cmd_o, RD);
        pd_req = 0; busy_i = 0; cmd_req_valid = 0;
        step();
    endtask

    task automatic t_precharge_wake();
        row_open_i = 2'b00; pd_req = 1; cmd_req_valid = 1; cmd_req_code = ACTV;
        #1 chk(cmd_req_ready == 0, "R10 stall at entry", cmd_req_ready, 0);
        step();
        chk(cke_o == 0, "R2 cke low", cke_o, 0);
        chk(cmd_o == NOP, "R10 cmd not issued", cmd_o, NOP);
        chk(pd_mode_o == 2'b01, "R4 precharge mode", pd_mode_o, 1);
        pd_req = 0; row_open_i = 2'b11;
        for (int i = 0; i < 3; i++) begin
            step();
            chk(cke_o == 0 && cmd_o == NOP, "R5 nop while low", cmd_o, NOP);
            chk(cmd_req_ready == 0, "R5 ready low", cmd_req_ready, 0);
            chk(pd_mode_o == 2'b01, "R4 mode held", pd_mode_o, 1);
        end
        wake_req = 1;
        step();
        wake_req = 0;
        chk(cke_o == 1, "R6 cke high", cke_o, 1);
        chk(cmd_o == NOP, "R6 nop", cmd_o, NOP);
        chk(pd_mode_o == 2'b00, "R6 mode cleared", pd_mode_o, 0);
        chk(timeout_o == 0, "R7 no timeout on wake", timeout_o, 0);
        #1 chk(cmd_req_ready == 0, "R8 stall exit 1", cmd_req_ready, 0);
        step();
        chk(cmd_o == NOP, "R8 nop exit 2", cmd_o, NOP);
        #1 chk(cmd_req_ready == 0, "R8 stall exit 2", cmd_req_ready, 0);
        step();
        #1 chk(cmd_req_ready == 1, "R8 ready after exit", cmd_req_ready, 1);
        step();
        chk(cmd_o == ACTV, "R9 stalled cmd issued", cmd_o, ACTV);
        cmd_req_valid = 0; row_open_i = 2'b00;
        step();
    endtask

    task automatic t_active_timeout();
        int n;
        row_open_i = 2'b01; pd_req = 1;
        step();
        pd_req = 0;
        chk(cke_o == 0, "R2 cke low", cke_o, 0);
        chk(pd_mode_o == 2'b10, "R4 active mode", pd_mode_o, 2);
        n = 1;
        while (cke_o == 0 && n < 200) begin
            step();
            if (cke_o == 0) n++;
        end
        chk(n == LIMIT, "R7 residency cycles", n, LIMIT);
        chk(timeout_o == 1, "R7 timeout flag", timeout_o, 1);
        chk(pd_mode_o == 2'b00, "R4 mode cleared", pd_mode_o, 0);
        step();
        chk(timeout_o == 0, "R7 timeout single", timeout_o, 0);
        row_open_i = 2'b00;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_passthru();
        t_busy_block();
        t_precharge_wake();
        t_active_timeout();
        t_passthru();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule